// File: doc/BRIEF.md
# Replicated Multi-Bank Read Memory

This block is a 512-word on-chip store that answers 24 reads in one clock without stalling. It keeps three complete copies of the array. Each copy is cut into eight banks of 64 words, and each copy takes its bank number from a different 3-bit slice of the 9-bit address. Copy 0 suits lanes that step through neighbouring words. Copy 1 suits strides of 8, and copy 2 suits strides of 64. Reaching 24 ports by plain duplication at two ports per copy would take twelve copies. Banking gets there with three.

Before compute starts, software-side logic loads the array through one write port while the mode input selects fill. Every write lands in all three copies in the same cycle. In compute mode the store is read-only. Each copy serves eight read lanes, and each lane's data comes back one clock after its request. For each copy, the block raises a flag in the request cycle whenever two of that copy's valid lanes hit the same bank. The block neither arbitrates nor stalls on such a clash; the data for the clashing lanes is simply undefined.

Top module: `repl_bank_mem`

## Requirements
- R1: While reset is low and in the first cycle after it, `rd_vld_o` is all zeros and `conflict` is all zeros.
- R2: A fill-mode write (`fill_mode`=1, `wr_en`=1) stores `wr_data` at `wr_addr` in all three copies, so any lane of any copy later reads that value at that address.
- R3: Copy r uses address bits [3r+2:3r] as its bank number. Its word index within the bank is the other six address bits, kept in their original order.
- R4: In compute mode, a valid lane's data and its `rd_vld_o` bit appear exactly one clock after the request. A lane that is not valid drives `rd_vld_o` low in the following cycle.
- R5: `conflict[r]` is high in the request cycle exactly when two or more valid lanes of copy r map to the same bank. Invalid lanes never count toward a clash.
- R6: Lanes 0–7 belong to copy 0, lanes 8–15 to copy 1 and lanes 16–23 to copy 2. Lanes in different copies never clash with each other. Lane l's address is `rd_addr[9l+8:9l]` and its data is `rd_data[16l+15:16l]`.
- R7: In fill mode all read requests are ignored: `conflict` stays zero and `rd_vld_o` is zero in the next cycle.
- R8: In compute mode, `wr_en` is ignored and the stored contents do not change.
- R9: With 24 valid lanes and no clash in any copy, all 24 lanes return correct data in the same cycle, back to back on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fill_mode | input | 1 | 1 = fill (writes accepted, reads ignored); 0 = compute |
| wr_en | input | 1 | Fill write strobe |
| wr_addr | input | 9 | Fill write address |
| wr_data | input | 16 | Fill write data |
| rd_vld_i | input | 24 | Per-lane read request valid |
| rd_addr | input | 216 | Packed lane addresses, 9 bits per lane |
| rd_data | output | 384 | Packed lane data, 16 bits per lane, one clock after the request |
| rd_vld_o | output | 24 | Per-lane data valid, one clock after the request |
| conflict | output | 3 | Per-copy bank clash flag, in the request cycle |

## Verification
The write port and the read lanes are the two functions that can share a cycle. The bench provokes this on purpose. Throughout the fill it keeps all 24 lanes requesting address 0, which would clash in every copy. It then expects no clash flag and no returned valid, and it expects every filled word to read back intact. It also pulses the write strobe in compute mode and then reads that word through each copy, expecting the original value. A sweep of all 512 base addresses with unit, 8 and 64 strides then checks that each copy's bank slice and word index are consistent.

// File: rtl/repl_bank_mem_pkg.sv
// Package: default geometry shared by the replicated banked memory.
// Assumes the address is wide enough to hold one bank slice per copy.
package repl_bank_mem_pkg;
    localparam int DEF_ADDR_W  = 9;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_BANK_W  = 3;
    localparam int DEF_NUM_REP = 3;
endpackage

// File: rtl/rbm_bank.sv
// Module: one single-read, single-write bank of a copy.
// Read data is registered, so it appears one clock after re.
// Assumes the owning copy never writes and reads in the same cycle.
module rbm_bank #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 6,
    localparam int DEPTH = 1 << WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [WORD_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // store a fill word
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read
    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end

    // R8
    no_rw_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re));
endmodule

// File: rtl/rbm_replica.sv
// Module: one full copy of the array, split into 2**BANK_W banks.
// The bank number is address slice [SLICE_LO +: BANK_W]. The word index is
// the remaining bits in order. It serves 2**BANK_W lanes and flags clashes.
// Assumes the caller gates lanes and the write strobe by mode.
module rbm_replica #(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 16,
    parameter int BANK_W   = 3,
    parameter int SLICE_LO = 0,
    localparam int NBANK   = 1 << BANK_W,
    localparam int LANES   = NBANK,
    localparam int WORD_W  = ADDR_W - BANK_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_go,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [LANES-1:0]        lane_vld,
    input  logic [LANES*ADDR_W-1:0] lane_addr_flat,
    output logic [LANES*DATA_W-1:0] lane_data_flat,
    output logic [LANES-1:0]        lane_vld_q,
    output logic                    conflict
);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << SLICE_LO) - 1);

    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        return a[SLICE_LO +: BANK_W];
    endfunction

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] t;
        t = ((a >> (SLICE_LO + BANK_W)) << SLICE_LO) | (a & LOW_MASK);
        return t[WORD_W-1:0];
    endfunction

    logic [ADDR_W-1:0] lane_addr   [LANES];
    logic [BANK_W-1:0] lane_bank_q [LANES];
    logic              bk_re       [NBANK];
    logic [WORD_W-1:0] bk_raddr    [NBANK];
    logic [DATA_W-1:0] bk_rdata    [NBANK];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_addr[l] = lane_addr_flat[l*ADDR_W +: ADDR_W];
        assign lane_data_flat[l*DATA_W +: DATA_W] = bk_rdata[lane_bank_q[l]];
    end

    // route each bank's read port to its lowest-numbered valid lane
    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            bk_re[b]    = 1'b0;
            bk_raddr[b] = '0;
        end
        for (int l = LANES - 1; l >= 0; l--) begin
            if (lane_vld[l]) begin
                bk_re[bank_of(lane_addr[l])]    = 1'b1;
                bk_raddr[bank_of(lane_addr[l])] = word_of(lane_addr[l]);
            end
        end
    end

    // detect two valid lanes aimed at one bank
    always_comb begin
        conflict = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            for (int j = i + 1; j < LANES; j++) begin
                if (lane_vld[i] && lane_vld[j] &&
                    bank_of(lane_addr[i]) == bank_of(lane_addr[j]))
                    conflict = 1'b1;
            end
        end
    end

    // remember each lane's bank for the return mux
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) lane_bank_q[l] <= bank_of(lane_addr[l]);
    end

    // lane valid pipeline, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) lane_vld_q <= '0;
        else        lane_vld_q <= lane_vld;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        rbm_bank #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go && (bank_of(wr_addr) == BANK_W'(b))),
            .waddr (word_of(wr_addr)),
            .wdata (wr_data),
            .re    (bk_re[b]),
            .raddr (bk_raddr[b]),
            .rdata (bk_rdata[b])
        );
    end

    // R5
    single_lane_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(lane_vld) < 2) |-> !conflict);
endmodule

// File: rtl/repl_bank_mem.sv
// Module: top of the replicated banked read memory. NUM_REP copies, where
// copy r banks on address slice [r*BANK_W +: BANK_W]. Fill mode writes all
// copies; compute mode serves NUM_REP * 2**BANK_W read lanes.
// Assumes ADDR_W >= NUM_REP * BANK_W.
module repl_bank_mem
    import repl_bank_mem_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int DATA_W  = DEF_DATA_W,
    parameter int BANK_W  = DEF_BANK_W,
    parameter int NUM_REP = DEF_NUM_REP,
    localparam int LPR    = 1 << BANK_W,
    localparam int LANES  = NUM_REP * LPR
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_mode,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [LANES-1:0]        rd_vld_i,
    input  logic [LANES*ADDR_W-1:0] rd_addr,
    output logic [LANES*DATA_W-1:0] rd_data,
    output logic [LANES-1:0]        rd_vld_o,
    output logic [NUM_REP-1:0]      conflict
);
    logic [LANES-1:0] lane_go;
    logic             wr_go;

    // mode gating: reads only in compute, writes only in fill
    always_comb begin
        lane_go = rd_vld_i & {LANES{!fill_mode}};
        wr_go   = wr_en & fill_mode;
    end

    for (genvar r = 0; r < NUM_REP; r++) begin : g_rep
        rbm_replica #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .BANK_W   (BANK_W),
            .SLICE_LO (r * BANK_W)
        ) u_rep (
            .clk            (clk),
            .rst_n          (rst_n),
            .wr_go          (wr_go),
            .wr_addr        (wr_addr),
            .wr_data        (wr_data),
            .lane_vld       (lane_go[r*LPR +: LPR]),
            .lane_addr_flat (rd_addr[r*LPR*ADDR_W +: LPR*ADDR_W]),
            .lane_data_flat (rd_data[r*LPR*DATA_W +: LPR*DATA_W]),
            .lane_vld_q     (rd_vld_o[r*LPR +: LPR]),
            .conflict       (conflict[r])
        );
    end

    // R7
    fill_no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_mode |-> (conflict == '0));
    // R7
    fill_silences_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_mode |=> (rd_vld_o == '0));
    // R4
    idle_lanes_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vld_i == '0) |=> (rd_vld_o == '0));
endmodule

// File: tb/repl_bank_mem_bench.sv
module repl_bank_mem_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 9;
    localparam int DW = 16;
    localparam int NL = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fill_mode = 1'b0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [NL-1:0]   rd_vld_i = '0;
    logic [NL*AW-1:0] rd_addr = '0;
    logic [NL*DW-1:0] rd_data;
    logic [NL-1:0]   rd_vld_o;
    logic [2:0]      conflict;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    repl_bank_mem u_repl_bank_mem (
        .clk(clk), .rst_n(rst_n), .fill_mode(fill_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_vld_i(rd_vld_i),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_vld_o(rd_vld_o),
        .conflict(conflict)
    );

    function automatic logic [DW-1:0] pattern(input int a);
        return DW'((a * 40503 + 4660) & 16'hFFFF);
    endfunction

    task automatic check(input string req, input logic [383:0] act, input logic [383:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_lane(input int l, input int a);
        rd_addr[l*AW +: AW] = AW'(a);
    endtask

    function automatic logic [DW-1:0] lane_data(input int l);
        return rd_data[l*DW +: DW];
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 vld in reset", 384'(rd_vld_o), 384'(0));
        check("R1 conflict in reset", 384'(conflict), 384'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 vld after reset", 384'(rd_vld_o), 384'(0));
        check("R1 conflict after reset", 384'(conflict), 384'(0));

        // R7/R2: fill every word while all lanes hammer address 0
        fill_mode = 1'b1;
        rd_vld_i = '1;
        rd_addr = '0;
        for (int a = 0; a < 512; a++) begin
            wr_en = 1'b1;
            wr_addr = AW'(a);
            wr_data = pattern(a);
            #1;
            check("R7 conflict in fill", 384'(conflict), 384'(0));
            @(negedge clk);
            check("R7 vld after fill read", 384'(rd_vld_o), 384'(0));
        end
        wr_en = 1'b0;
        rd_vld_i = '0;
        fill_mode = 1'b0;
        @(negedge clk);

        // R8: writes ignored in compute mode
        wr_en = 1'b1;
        wr_addr = AW'(7);
        wr_data = ~pattern(7);
        @(negedge clk);
        wr_en = 1'b0;
        rd_vld_i = '0;
        rd_vld_i[0] = 1'b1; rd_vld_i[8] = 1'b1; rd_vld_i[16] = 1'b1;
        set_lane(0, 7); set_lane(8, 7); set_lane(16, 7);
        @(negedge clk);
        check("R8 copy0 word 7", 384'(lane_data(0)), 384'(pattern(7)));
        check("R8 copy1 word 7", 384'(lane_data(8)), 384'(pattern(7)));
        check("R8 copy2 word 7", 384'(lane_data(16)), 384'(pattern(7)));

        // R2/R3/R4/R6/R9: full sweep, strides 1, 8, 64 per copy
        for (int k = 0; k < 512; k++) begin
            rd_vld_i = '1;
            for (int l = 0; l < 8; l++) begin
                set_lane(l, (k + l) % 512);
                set_lane(8 + l, (k + 8 * l) % 512);
                set_lane(16 + l, (k + 64 * l) % 512);
            end
            #1;
            check("R5 no clash on strided set", 384'(conflict), 384'(0));
            @(negedge clk);
            check("R4 vld one clock later", 384'(rd_vld_o), 384'({NL{1'b1}}));
            for (int l = 0; l < 8; l++) begin
                check("R9 copy0 lane", 384'(lane_data(l)), 384'(pattern((k + l) % 512)));
                check("R3 copy1 lane", 384'(lane_data(8 + l)), 384'(pattern((k + 8 * l) % 512)));
                check("R6 copy2 lane", 384'(lane_data(16 + l)), 384'(pattern((k + 64 * l) % 512)));
            end
        end
        rd_vld_i = '0;
        @(negedge clk);
        check("R4 idle lanes drop vld", 384'(rd_vld_o), 384'(0));

        // R5/R6: clash cases, judged in the request cycle
        rd_vld_i = '0; rd_vld_i[0] = 1'b1; rd_vld_i[3] = 1'b1;
        set_lane(0, 5); set_lane(3, 13);
        #1; check("R5 copy0 clash", 384'(conflict), 384'(3'b001));
        @(negedge clk);
        rd_vld_i = '0; rd_vld_i[8] = 1'b1; rd_vld_i[15] = 1'b1;
        set_lane(8, 8); set_lane(15, 9);
        #1; check("R5 copy1 clash", 384'(conflict), 384'(3'b010));
        @(negedge clk);
        rd_vld_i = '0; rd_vld_i[16] = 1'b1; rd_vld_i[17] = 1'b1;
        set_lane(16, 64); set_lane(17, 65);
        #1; check("R5 copy2 clash", 384'(conflict), 384'(3'b100));
        @(negedge clk);
        rd_vld_i = '0; rd_vld_i[0] = 1'b1;
        set_lane(0, 5); set_lane(1, 5);
        #1; check("R5 invalid lane ignored", 384'(conflict), 384'(0));
        @(negedge clk);
        rd_vld_i = '0; rd_vld_i[0] = 1'b1; rd_vld_i[8] = 1'b1;
        set_lane(0, 5); set_lane(8, 5);
        #1; check("R6 cross-copy no clash", 384'(conflict), 384'(0));
        @(negedge clk);
        check("R6 lane 8 data", 384'(lane_data(8)), 384'(pattern(5)));
        rd_vld_i = '0;
        @(negedge clk);
        finish_run();
    end
endmodule